// File: doc/BRIEF.md
# Port Power Discharge Sequencer

This block runs the discharge of a downstream port after its power has been taken away. When the attach controller reports a detach, the block first turns on a low-ohm pull-down on the port's bus supply for a fixed number of clock cycles. It then leaves only a high-ohm bleed path engaged, and keeps it engaged for as long as no sink termination is seen on the CC lines. If the cable power had been supplied on one of the two CC pins, that pin alone gets its own pull-down. This pull-down stays on for a minimum number of cycles, and after that until the pin's low-voltage comparator reports that the pin has settled.

A combined done flag goes high only when three conditions hold: no strong VBUS pull-down is active, the VBUS comparator reports the bus below its threshold, and no CC-pin discharge is running. A new power application is granted only while a sink termination is present, the done flag is high, and no detach is arriving in the same cycle. A sink that reattaches in the middle of a discharge therefore waits until the discharge has finished.

Top module: `dchg_seq`

## Requirements
- R1: While reset is low, and after it is released with no detach, the strong VBUS pull-down and both CC-pin pull-downs are off.
- R2: A detach sampled on a clock edge turns the strong VBUS pull-down on from that edge, for exactly STRONG_CYCLES cycles.
- R3: The VBUS bleed enable is high exactly when the strong pull-down is off and no sink termination is reported. It is never high together with the strong pull-down.
- R4: `vconnSrc` uses bit 0 for the CC1 pin and bit 1 for the CC2 pin, and at most one bit may be set. A detach copies it to `vconnDisEn`, so only the pin that carried cable power is discharged. When `vconnSrc` is 0 at the detach, no CC-pin pull-down turns on.
- R5: A CC-pin pull-down, once started, stays on for at least VCONN_MIN_CYCLES cycles, even if the below-threshold flag is already high.
- R6: Once the minimum has elapsed, the CC-pin pull-down turns off on the first edge at which `vconnBelowFlag` is sampled high. Until then it stays on.
- R7: `dischargeDone` is high exactly when the strong pull-down is off, `vbusAboveFlag` is low, and no CC-pin pull-down is on.
- R8: `powerGrant` equals `sinkTermSeen` AND `dischargeDone` AND NOT `detachEvt`. It is never high while the strong pull-down is on.
- R9: A detach that arrives during an active strong interval restarts the interval, so the strong pull-down stays on for STRONG_CYCLES cycles after that new detach. It also restarts the CC-pin sequence, using the `vconnSrc` value sampled at that new detach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| detachEvt | input | 1 | One-cycle detach indication from the attach controller |
| vconnSrc | input | 2 | CC pin that carried cable power (bit0 CC1, bit1 CC2), one-hot or zero |
| sinkTermSeen | input | 1 | Sink termination currently present on the CC lines |
| vbusAboveFlag | input | 1 | Comparator: VBUS above its not-discharged threshold |
| vconnBelowFlag | input | 1 | Comparator: the discharged CC pin is below its threshold |
| vbusStrongEn | output | 1 | Low-ohm VBUS pull-down enable |
| vbusBleedEn | output | 1 | High-ohm VBUS bleed enable |
| vconnDisEn | output | 2 | Per-pin CC pull-down enables (bit0 CC1, bit1 CC2) |
| dischargeDone | output | 1 | All discharge complete |
| powerGrant | output | 1 | Permission to apply power to a new attachment |

## Verification
The properties assume two things about the inputs: `vconnSrc` never has both bits set, and `detachEvt` comes as an event rather than being held high for long stretches. The comparator flags are allowed to take any value in any cycle. The stimulus picks `vconnSrc` from zero, CC1 or CC2 only, and raises detach on roughly one cycle in four hundred. It toggles both comparator flags and the sink termination freely. On top of this random traffic, directed sequences cover the corner cases: an early settled flag, a late settled flag, a restarted strong interval, and a reattach during discharge.

// File: rtl/dchg_pkg.sv
package dchg_pkg;

  // Strobes sent from the control FSM to the interval counters
  typedef struct packed {
    logic vbusLoad;
    logic vbusDec;
    logic vconnLoad;
    logic vconnDec;
  } dchgStrobes_t;

  typedef enum logic {
    VB_REST   = 1'b0,
    VB_STRONG = 1'b1
  } vbusPhase_t;

endpackage

// File: rtl/dchg_timer_dp.sv
module dchg_timer_dp
  import dchg_pkg::*;
#(
  parameter int STRONG_CYCLES    = 262,
  parameter int VCONN_MIN_CYCLES = 65
) (
  input  logic         clk,
  input  logic         rstN,
  input  dchgStrobes_t strobes,
  output logic         vbusTimerZero,
  output logic         vconnTimerZero
);

  localparam int SW = (STRONG_CYCLES    > 1) ? $clog2(STRONG_CYCLES)    : 1;
  localparam int VW = (VCONN_MIN_CYCLES > 1) ? $clog2(VCONN_MIN_CYCLES) : 1;
  localparam logic [SW-1:0] S_LOAD = SW'(STRONG_CYCLES - 1);
  localparam logic [VW-1:0] V_LOAD = VW'(VCONN_MIN_CYCLES - 1);

  logic [SW-1:0] vbusCnt;
  logic [VW-1:0] vconnCnt;

  // Strong-interval down counter
  always_ff @(posedge clk) begin
    if (!rstN)                 vbusCnt <= '0;
    else if (strobes.vbusLoad) vbusCnt <= S_LOAD;
    else if (strobes.vbusDec)  vbusCnt <= vbusCnt - 1'b1;
  end

  // Minimum CC-pin discharge down counter
  always_ff @(posedge clk) begin
    if (!rstN)                  vconnCnt <= '0;
    else if (strobes.vconnLoad) vconnCnt <= V_LOAD;
    else if (strobes.vconnDec)  vconnCnt <= vconnCnt - 1'b1;
  end

  assign vbusTimerZero  = (vbusCnt  == '0);
  assign vconnTimerZero = (vconnCnt == '0);

endmodule

// File: rtl/dchg_ctrl.sv
module dchg_ctrl
  import dchg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         detachEvt,
  input  logic [1:0]   vconnSrc,
  input  logic         vconnBelowFlag,
  input  logic         vbusTimerZero,
  input  logic         vconnTimerZero,
  output dchgStrobes_t strobes,
  output logic         strongOn,
  output logic         vconnActive,
  output logic [1:0]   vconnPin
);

  vbusPhase_t phase, phaseNext;
  logic       activeNext;
  logic [1:0] pinNext;

  always_comb begin
    strobes           = '0;
    strobes.vbusLoad  = detachEvt;
    strobes.vconnLoad = detachEvt;
    strobes.vbusDec   = !detachEvt && (phase == VB_STRONG) && !vbusTimerZero;
    strobes.vconnDec  = !detachEvt && vconnActive && !vconnTimerZero;
  end

  always_comb begin
    phaseNext = phase;
    if (detachEvt)                                 phaseNext = VB_STRONG;
    else if (phase == VB_STRONG && vbusTimerZero) phaseNext = VB_REST;
  end

  always_comb begin
    activeNext = vconnActive;
    pinNext    = vconnPin;
    if (detachEvt) begin
      activeNext = |vconnSrc;
      pinNext    = vconnSrc;
    end else if (vconnActive && vconnTimerZero && vconnBelowFlag) begin
      activeNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= VB_REST;
      vconnActive <= 1'b0;
      vconnPin    <= 2'b00;
    end else begin
      phase       <= phaseNext;
      vconnActive <= activeNext;
      vconnPin    <= pinNext;
    end
  end

  assign strongOn = (phase == VB_STRONG);

endmodule

// File: rtl/dchg_seq.sv
module dchg_seq
  import dchg_pkg::*;
#(
  parameter int STRONG_CYCLES    = 262,
  parameter int VCONN_MIN_CYCLES = 65
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       detachEvt,
  input  logic [1:0] vconnSrc,
  input  logic       sinkTermSeen,
  input  logic       vbusAboveFlag,
  input  logic       vconnBelowFlag,
  output logic       vbusStrongEn,
  output logic       vbusBleedEn,
  output logic [1:0] vconnDisEn,
  output logic       dischargeDone,
  output logic       powerGrant
);

  dchgStrobes_t strobes;
  logic vbusTimerZero, vconnTimerZero;
  logic strongOn, vconnActive;
  logic [1:0] vconnPin;

  dchg_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .detachEvt      (detachEvt),
    .vconnSrc       (vconnSrc),
    .vconnBelowFlag (vconnBelowFlag),
    .vbusTimerZero  (vbusTimerZero),
    .vconnTimerZero (vconnTimerZero),
    .strobes        (strobes),
    .strongOn       (strongOn),
    .vconnActive    (vconnActive),
    .vconnPin       (vconnPin)
  );

  dchg_timer_dp #(
    .STRONG_CYCLES    (STRONG_CYCLES),
    .VCONN_MIN_CYCLES (VCONN_MIN_CYCLES)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .vbusTimerZero  (vbusTimerZero),
    .vconnTimerZero (vconnTimerZero)
  );

  assign vbusStrongEn  = strongOn;
  assign vbusBleedEn   = !strongOn && !sinkTermSeen;
  assign vconnDisEn    = vconnActive ? vconnPin : 2'b00;
  assign dischargeDone = !strongOn && !vbusAboveFlag && !vconnActive;
  assign powerGrant    = sinkTermSeen && dischargeDone && !detachEvt;

endmodule

// File: rtl/dchg_seq_chk.sv
module dchg_seq_chk #(
  parameter int STRONG_CYCLES    = 262,
  parameter int VCONN_MIN_CYCLES = 65
) (
  input logic       clk,
  input logic       rstN,
  input logic       detachEvt,
  input logic [1:0] vconnSrc,
  input logic       sinkTermSeen,
  input logic       vbusAboveFlag,
  input logic       vconnBelowFlag,
  input logic       vbusStrongEn,
  input logic       vbusBleedEn,
  input logic [1:0] vconnDisEn,
  input logic       dischargeDone,
  input logic       powerGrant
);

  int unsigned strongRun;
  int unsigned vconnRun;

  // Count enabled cycles since the most recent detach
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strongRun <= 0;
      vconnRun  <= 0;
    end else begin
      if (detachEvt)         strongRun <= 0;
      else if (vbusStrongEn) strongRun <= strongRun + 1;
      if (detachEvt)         vconnRun  <= 0;
      else if (|vconnDisEn)  vconnRun  <= vconnRun + 1;
    end
  end

  p_strong_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    detachEvt |=> vbusStrongEn);

  p_strong_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!vbusStrongEn && $past(vbusStrongEn) && !$past(detachEvt)) |-> (strongRun == STRONG_CYCLES));

  p_bleed_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    vbusStrongEn |-> !vbusBleedEn);

  p_bleed_sink_r3: assert property (@(posedge clk) disable iff (!rstN)
    sinkTermSeen |-> !vbusBleedEn);

  p_pin_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vconnDisEn));

  p_pin_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    detachEvt |=> (vconnDisEn == $past(vconnSrc)));

  p_min_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((vconnDisEn == 2'b00) && ($past(vconnDisEn) != 2'b00) && !$past(detachEvt))
      |-> (vconnRun >= VCONN_MIN_CYCLES));

  p_done_strong_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vbusStrongEn || (vconnDisEn != 2'b00) || vbusAboveFlag) |-> !dischargeDone);

  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(vbusStrongEn && powerGrant));

  p_grant_sink_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerGrant |-> (sinkTermSeen && dischargeDone));

endmodule

bind dchg_seq dchg_seq_chk #(
  .STRONG_CYCLES    (STRONG_CYCLES),
  .VCONN_MIN_CYCLES (VCONN_MIN_CYCLES)
) chk_i (.*);

// File: tb/dchg_seq_tb_top.sv
`timescale 1ns/1ps
module dchg_seq_tb_top;

  localparam int STRONG = 262;
  localparam int VMIN   = 65;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       detachEvt = 1'b0;
  logic [1:0] vconnSrc = 2'b00;
  logic       sinkTermSeen = 1'b0;
  logic       vbusAboveFlag = 1'b0;
  logic       vconnBelowFlag = 1'b0;
  logic       vbusStrongEn, vbusBleedEn, dischargeDone, powerGrant;
  logic [1:0] vconnDisEn;

  dchg_seq #(.STRONG_CYCLES(STRONG), .VCONN_MIN_CYCLES(VMIN)) dut_i (
    .clk(clk), .rstN(rstN), .detachEvt(detachEvt), .vconnSrc(vconnSrc),
    .sinkTermSeen(sinkTermSeen), .vbusAboveFlag(vbusAboveFlag),
    .vconnBelowFlag(vconnBelowFlag), .vbusStrongEn(vbusStrongEn),
    .vbusBleedEn(vbusBleedEn), .vconnDisEn(vconnDisEn),
    .dischargeDone(dischargeDone), .powerGrant(powerGrant)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Reference state derived from the requirements
  int         mStrong = 0;
  int         mVLeft  = 0;
  bit         mVAct   = 0;
  logic [1:0] mVPin   = 2'b00;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit expStrong();
    return mStrong > 0;
  endfunction
  function automatic bit expDone();
    return !expStrong() && !vbusAboveFlag && !mVAct;
  endfunction

  task automatic checkOutputs();
    chk("R2", "strong", vbusStrongEn, expStrong());
    chk("R3", "bleed", vbusBleedEn, !expStrong() && !sinkTermSeen);
    chk("R4", "vconnDisEn", vconnDisEn, mVAct ? mVPin : 2'b00);
    chk("R7", "done", dischargeDone, expDone());
    chk("R8", "grant", powerGrant, sinkTermSeen && expDone() && !detachEvt);
  endtask

  task automatic modelAdvance();
    if (!rstN) begin
      mStrong = 0; mVAct = 0; mVLeft = 0; mVPin = 2'b00;
    end else if (detachEvt) begin
      mStrong = STRONG; mVAct = (vconnSrc != 2'b00); mVPin = vconnSrc; mVLeft = VMIN;
    end else begin
      if (mStrong > 0) mStrong--;
      if (mVAct) begin
        if (mVLeft <= 1 && vconnBelowFlag) mVAct = 0;
        else if (mVLeft > 1) mVLeft--;
      end
    end
  endtask

  // Called at a falling edge with inputs already set
  task automatic step();
    #1;
    checkOutputs();
    modelAdvance();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4711));
    @(negedge clk);
    repeat (4) step();
    // R1: reset state
    chk("R1", "strong in reset", vbusStrongEn, 0);
    chk("R1", "vconn in reset", vconnDisEn, 0);
    rstN = 1'b1;
    repeat (3) step();
    chk("R1", "strong after reset", vbusStrongEn, 0);
    chk("R1", "vconn after reset", vconnDisEn, 0);

    // R2 + R5: single detach, CC1 already settled
    vconnSrc = 2'b01; vconnBelowFlag = 1'b1; detachEvt = 1'b1; step();
    detachEvt = 1'b0; vconnSrc = 2'b00;
    cnt = 0;
    for (int i = 0; i < 400; i++) begin
      if (vbusStrongEn) cnt++;
      step();
    end
    chk("R2", "strong length", cnt, STRONG);
    chk("R3", "bleed after strong", vbusBleedEn, 1);
    sinkTermSeen = 1'b1; step();
    chk("R3", "bleed with sink", vbusBleedEn, 0);
    chk("R8", "grant after done", powerGrant, 1);
    sinkTermSeen = 1'b0;

    vconnSrc = 2'b01; vconnBelowFlag = 1'b1; detachEvt = 1'b1; step();
    detachEvt = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (vconnDisEn != 2'b00) cnt++;
      step();
    end
    chk("R5", "vconn min length", cnt, VMIN);

    // R6: CC2, settles late
    vconnSrc = 2'b10; vconnBelowFlag = 1'b0; detachEvt = 1'b1; step();
    detachEvt = 1'b0;
    cnt = 0;
    for (int i = 0; i < 150; i++) begin
      vconnBelowFlag = (i >= 100);
      if (vconnDisEn == 2'b10) cnt++;
      step();
    end
    chk("R6", "vconn late end", cnt, 101);
    repeat (300) step();

    // R4: no VCONN source
    vconnSrc = 2'b00; detachEvt = 1'b1; step();
    detachEvt = 1'b0;
    chk("R4", "no pin discharged", vconnDisEn, 0);
    repeat (300) step();

    // R9 + R8: restart during strong, reattach mid discharge
    detachEvt = 1'b1; step();
    detachEvt = 1'b0;
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      detachEvt = (i == 99);
      sinkTermSeen = (i >= 50);
      if (i == 200) chk("R8", "grant held during strong", powerGrant, 0);
      if (vbusStrongEn) cnt++;
      step();
    end
    detachEvt = 1'b0;
    chk("R9", "restarted strong length", cnt, 100 + STRONG);
    chk("R8", "grant after restart done", powerGrant, 1);
    vbusAboveFlag = 1'b1; step();
    chk("R7", "done with vbus high", dischargeDone, 0);
    vbusAboveFlag = 1'b0; sinkTermSeen = 1'b0;

    // Random traffic
    for (int i = 0; i < 30000; i++) begin
      int s;
      detachEvt = ($urandom % 400) == 0;
      s = $urandom % 3;
      vconnSrc = (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10;
      if (($urandom % 50) == 0) sinkTermSeen = ~sinkTermSeen;
      if (($urandom % 20) == 0) vbusAboveFlag = ~vbusAboveFlag;
      if (($urandom % 15) == 0) vconnBelowFlag = ~vconnBelowFlag;
      step();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule